// File: doc/BRIEF.md
# Power-Management Bus Transaction Sequencer

This block is the host side of a two-wire open-drain management bus. It takes one request and runs the whole command-coded transaction on the wire. The request carries a kind, a 7-bit target address, a command code and up to two data bytes. The supported kinds are command-only, one-byte write, two-byte write, one-byte read, two-byte read and length-prefixed block read. The block makes the start, repeated-start and stop conditions and shifts every byte out or in. It checks the target's acknowledge after each transmitted byte and decides its own acknowledge on each received byte.

Both bus lines are driven through active-high pull-low enables, and the data line is sampled back through `sda_in`. Each bit occupies one slot of `SCL_DIV` system clocks, split into four equal quarters. Received bytes leave on a strobe-only byte stream, which marks the final byte. A finished transaction gives a one-cycle `done` and an `error` flag that stays valid until the next request.

Top module: `pmb_txn_seq`

## Requirements
- R1: After reset both line enables are low (lines released), `busy` and `done` are low and `req_ready` is high.
- R2: An address byte is `{addr, dir}` with dir 1 for read and 0 for write. Every byte leaves most significant bit first. A data bit is placed while SCL is low and held through the whole SCL high time.
- R3: SDA changes while SCL is high only to form a start (falling) or a stop (rising) condition. Each transaction has exactly one stop, one start for write kinds and two starts (start plus repeated start) for read kinds.
- R4: Kind encoding: 0 command-only, 1 one-byte write, 2 two-byte write, 3 one-byte read, 4 two-byte read, 5 block read. Write kinds send the address+write byte and the command, then `wdata[7:0]` (kinds 1, 2), then `wdata[15:8]` (kind 2 only).
- R5: Read kinds send the address+write byte and the command, then a repeated start, then the address+read byte, and then receive.
- R6: A one-byte read receives one byte and does not acknowledge it. A two-byte read receives the low byte first with acknowledge, then the high byte without acknowledge.
- R7: In a block read the first received byte is a count N (0 to 255) and N bytes follow. Every byte except the last is acknowledged. With N = 0 the count byte is the last byte and is not acknowledged.
- R8: When a target acknowledge is missing on any transmitted byte, no further byte is sent and a stop is issued. `done` then comes with `error` high.
- R9: A transaction accepted at a clock edge raises `done` exactly S*SCL_DIV cycles later. S counts one slot for the start, nine per transmitted or received byte, one for the repeated start and one for the stop.
- R10: Each received byte, the block count included, appears once on `rd_byte` with a one-cycle `rd_valid`, in wire order. `rd_last` is set on the byte the master did not acknowledge.
- R11: `done` lasts one cycle. `error` is low after a successful transaction and is cleared when a new request is accepted. `req_ready` is low while a transaction runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_ready | output | 1 | Sequencer idle |
| req_kind | input | 3 | Transaction kind (encoding in R4) |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command code |
| req_wdata | input | 16 | Write data, low byte sent first |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| error | output | 1 | Missing target acknowledge in last transaction |
| rd_valid | output | 1 | Received byte strobe |
| rd_byte | output | 8 | Received byte |
| rd_last | output | 1 | Strobed byte is the final one |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The completion pulse is due a fixed number of clocks after the accepting edge: the slot count of R9 times `SCL_DIV`. The bench counts rising edges from that edge and compares the count it holds on the first falling edge where `done` is seen. Nothing is received on the stream before then. Each byte is taken at the falling edge that follows the strobing rising edge. Bytes on the wire and the master's acknowledges are recorded by a target model at the SCL edges themselves. They are checked once the pulse has arrived, so their exact cycle does not enter the comparison.

// File: rtl/pmb_pkg.sv
`timescale 1ns/1ps
package pmb_pkg;

  typedef enum logic [2:0] {
    K_SEND     = 3'd0,
    K_WR_BYTE  = 3'd1,
    K_WR_WORD  = 3'd2,
    K_RD_BYTE  = 3'd3,
    K_RD_WORD  = 3'd4,
    K_RD_BLOCK = 3'd5
  } pmb_kind_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_START,
    PH_ADDR_W,
    PH_CMD,
    PH_DATA_LO,
    PH_DATA_HI,
    PH_RESTART,
    PH_ADDR_R,
    PH_RECV,
    PH_STOP
  } pmb_phase_e;

  function automatic logic kind_is_read(input pmb_kind_e k);
    return (k == K_RD_BYTE) || (k == K_RD_WORD) || (k == K_RD_BLOCK);
  endfunction

  function automatic logic phase_is_byte(input pmb_phase_e p);
    case (p)
      PH_ADDR_W, PH_CMD, PH_DATA_LO, PH_DATA_HI, PH_ADDR_R, PH_RECV: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Phase that follows a transmitted byte the target acknowledged.
  function automatic pmb_phase_e tx_after(input pmb_phase_e p, input pmb_kind_e k);
    case (p)
      PH_ADDR_W:  return PH_CMD;
      PH_CMD: begin
        if (kind_is_read(k)) return PH_RESTART;
        if (k == K_WR_BYTE || k == K_WR_WORD) return PH_DATA_LO;
        return PH_STOP;
      end
      PH_DATA_LO: return (k == K_WR_WORD) ? PH_DATA_HI : PH_STOP;
      PH_ADDR_R:  return PH_RECV;
      default:    return PH_STOP;
    endcase
  endfunction

  // Master acknowledge for a received byte; left counts bytes still due, this one included.
  function automatic logic master_acks(input pmb_kind_e k, input logic first,
                                       input logic [8:0] left, input logic [7:0] data);
    if (k == K_RD_BLOCK && first) return data != 8'd0;
    return left != 9'd1;
  endfunction

  // Line shapes per quarter of a slot.
  function automatic logic scl_low_at(input pmb_phase_e p, input logic [1:0] q);
    case (p)
      PH_IDLE:  return 1'b0;
      PH_START: return q == 2'd3;
      PH_STOP:  return q == 2'd0;
      default:  return (q == 2'd0) || (q == 2'd3);
    endcase
  endfunction

  function automatic logic sda_low_at(input pmb_phase_e p, input logic [1:0] q);
    case (p)
      PH_START, PH_RESTART: return q >= 2'd2;
      PH_STOP:              return q <= 2'd1;
      default:              return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pmb_quarter_timer.sv
`timescale 1ns/1ps
module pmb_quarter_timer #(
  parameter int QTR = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic [1:0] q,
  output logic       tick
);
  localparam int QW = (QTR > 2) ? $clog2(QTR) : 1;
  localparam logic [QW-1:0] LAST = QW'(QTR - 1);

  logic [QW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (!run) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      q   <= q + 2'd1;
    end else begin
      cnt <= cnt + QW'(1);
    end
  end

  // R9: every quarter restarts its count after the tick
  p_quarter_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));

endmodule

// File: rtl/pmb_frame.sv
`timescale 1ns/1ps
module pmb_frame (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       load_rx,
  input  logic [7:0] load_byte,
  input  logic       slot_end,
  input  logic       sample_pt,
  input  logic       sda_in,
  input  logic       mack,
  output logic [3:0] bit_idx,
  output logic       drive_low,
  output logic [7:0] rx_data,
  output logic       slave_ack
);
  logic       rx_mode;
  logic [7:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx   <= 4'd8;
      rx_mode   <= 1'b0;
      tx_sh     <= 8'hFF;
      rx_data   <= 8'h00;
      slave_ack <= 1'b0;
    end else begin
      if (load) begin
        bit_idx   <= 4'd0;
        rx_mode   <= load_rx;
        tx_sh     <= load_byte;
        slave_ack <= 1'b0;
      end else if (slot_end && bit_idx != 4'd8) begin
        bit_idx <= bit_idx + 4'd1;
        tx_sh   <= {tx_sh[6:0], 1'b1};
      end
      if (sample_pt && rx_mode && bit_idx < 4'd8) rx_data <= {rx_data[6:0], sda_in};
      if (sample_pt && !rx_mode && bit_idx == 4'd8) slave_ack <= !sda_in;
    end
  end

  // Slot 8 is the acknowledge slot: released for the target on writes, master decision on reads.
  assign drive_low = (bit_idx == 4'd8) ? (rx_mode && mack) : (!rx_mode && !tx_sh[7]);

endmodule

// File: rtl/pmb_txn_seq.sv
`timescale 1ns/1ps
module pmb_txn_seq
  import pmb_pkg::*;
#(
  parameter int SCL_DIV = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_kind,
  input  logic [6:0]  req_addr,
  input  logic [7:0]  req_cmd,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic        rd_valid,
  output logic [7:0]  rd_byte,
  output logic        rd_last,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int QTR = (SCL_DIV / 4 < 2) ? 2 : SCL_DIV / 4;

  pmb_phase_e  phase, phase_nxt;
  pmb_kind_e   kind_r;
  logic [6:0]  addr_r;
  logic [7:0]  cmd_r;
  logic [15:0] wdata_r;
  logic        rx_first;
  logic [8:0]  rx_left;

  logic [1:0]  q;
  logic        tick, slot_end, sample_pt;
  logic [3:0]  bit_idx;
  logic        frame_drive, slave_ack, mack;
  logic [7:0]  rx_data;
  logic        frame_load, frame_rx, frame_end, accept, tx_nack;
  logic [7:0]  load_byte;
  logic        ev_start_q, ev_stop_q;

  assign req_ready = (phase == PH_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;

  pmb_quarter_timer #(.QTR(QTR)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(phase != PH_IDLE), .q(q), .tick(tick)
  );

  assign slot_end  = tick && (q == 2'd3);
  assign sample_pt = tick && (q == 2'd1);
  assign frame_end = slot_end && phase_is_byte(phase) && (bit_idx == 4'd8);
  assign tx_nack   = frame_end && (phase != PH_RECV) && !slave_ack;
  assign mack      = master_acks(kind_r, rx_first, rx_left, rx_data);

  always_comb begin
    phase_nxt = phase;
    if (slot_end) begin
      case (phase)
        PH_START:   phase_nxt = PH_ADDR_W;
        PH_RESTART: phase_nxt = PH_ADDR_R;
        PH_STOP:    phase_nxt = PH_IDLE;
        PH_RECV:    if (bit_idx == 4'd8) phase_nxt = mack ? PH_RECV : PH_STOP;
        PH_ADDR_W, PH_CMD, PH_DATA_LO, PH_DATA_HI, PH_ADDR_R:
          if (bit_idx == 4'd8) phase_nxt = slave_ack ? tx_after(phase, kind_r) : PH_STOP;
        default:    phase_nxt = phase;
      endcase
    end
  end

  always_comb begin
    case (phase_nxt)
      PH_ADDR_W:  load_byte = {addr_r, 1'b0};
      PH_CMD:     load_byte = cmd_r;
      PH_DATA_LO: load_byte = wdata_r[7:0];
      PH_DATA_HI: load_byte = wdata_r[15:8];
      PH_ADDR_R:  load_byte = {addr_r, 1'b1};
      default:    load_byte = 8'hFF;
    endcase
  end

  assign frame_load = slot_end && phase_is_byte(phase_nxt) &&
                      (!phase_is_byte(phase) || bit_idx == 4'd8);
  assign frame_rx   = (phase_nxt == PH_RECV);

  pmb_frame i_frame (
    .clk(clk), .rst_n(rst_n), .load(frame_load), .load_rx(frame_rx), .load_byte(load_byte),
    .slot_end(slot_end), .sample_pt(sample_pt), .sda_in(sda_in), .mack(mack),
    .bit_idx(bit_idx), .drive_low(frame_drive), .rx_data(rx_data), .slave_ack(slave_ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      kind_r     <= K_SEND;
      addr_r     <= 7'd0;
      cmd_r      <= 8'd0;
      wdata_r    <= 16'd0;
      rx_first   <= 1'b0;
      rx_left    <= 9'd0;
      done       <= 1'b0;
      error      <= 1'b0;
      rd_valid   <= 1'b0;
      rd_byte    <= 8'd0;
      rd_last    <= 1'b0;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
      ev_start_q <= 1'b0;
      ev_stop_q  <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (accept) begin
        phase    <= PH_START;
        kind_r   <= pmb_kind_e'(req_kind);
        addr_r   <= req_addr;
        cmd_r    <= req_cmd;
        wdata_r  <= req_wdata;
        error    <= 1'b0;
        rx_first <= 1'b1;
        rx_left  <= (pmb_kind_e'(req_kind) == K_RD_WORD) ? 9'd2 : 9'd1;
      end else begin
        phase <= phase_nxt;
        if (tx_nack) error <= 1'b1;
        if (frame_end && phase == PH_RECV) begin
          rd_valid <= 1'b1;
          rd_byte  <= rx_data;
          rd_last  <= !mack;
          rx_first <= 1'b0;
          rx_left  <= (rx_first && kind_r == K_RD_BLOCK) ? {1'b0, rx_data} : rx_left - 9'd1;
        end
        if (slot_end && phase == PH_STOP) done <= 1'b1;
      end
      scl_oe     <= scl_low_at(phase, q);
      sda_oe     <= phase_is_byte(phase) ? frame_drive : sda_low_at(phase, q);
      ev_start_q <= (phase == PH_START || phase == PH_RESTART) && (q == 2'd2);
      ev_stop_q  <= (phase == PH_STOP) && (q == 2'd2);
    end
  end

  // R3: with SCL high across two cycles, an SDA move must be a start or stop
  p_sda_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe))) |-> (ev_start_q || ev_stop_q));

  // R11: completion pulse lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion always follows a stop slot and leaves the sequencer idle
  p_done_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phase == PH_STOP) && req_ready));

  // R8: missing target acknowledge goes straight to stop with the error flag
  p_nack_aborts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nack |=> (phase == PH_STOP && error));

  // R10: stream strobes only come out of the receive phase
  p_stream_in_recv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(phase == PH_RECV));

endmodule

// File: tb/test_pmb_txn_seq.sv
`timescale 1ns/1ps
module test_pmb_txn_seq;
  localparam int DIV = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, busy, done, error;
  logic [2:0]  req_kind;
  logic [6:0]  req_addr;
  logic [7:0]  req_cmd;
  logic [15:0] req_wdata;
  logic        rd_valid, rd_last, scl_oe, sda_oe;
  logic [7:0]  rd_byte;
  logic        slave_pull = 1'b0;
  wire         scl_w = ~scl_oe;
  wire         sda_w = ~(sda_oe | slave_pull);

  pmb_txn_seq #(.SCL_DIV(DIV)) i_pmb_txn_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_cmd(req_cmd), .req_wdata(req_wdata),
    .busy(busy), .done(done), .error(error), .rd_valid(rd_valid), .rd_byte(rd_byte),
    .rd_last(rd_last), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w)
  );

  int tests = 0, fails = 0, total_cyc = 0;
  always @(posedge clk) total_cyc++;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- target model ----------------
  logic [7:0] rsp [0:299];
  logic [7:0] wlog [0:15];
  logic       mlog [0:299];
  int n_wr, n_start, n_stop, n_mack, nack_at, bitcnt, rdi;
  bit skip, in_read, first_byte, go_read, mack_now, nk_now;
  logic [7:0] sh;

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    n_start++; bitcnt = 0; skip = 1; in_read = 0; first_byte = 1; go_read = 0; slave_pull = 0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    n_stop++; bitcnt = 0; in_read = 0; go_read = 0; slave_pull = 0;
  end
  always @(posedge scl_w) begin
    if (bitcnt < 8) begin
      if (!in_read) sh = {sh[6:0], sda_w};
    end else if (in_read) begin
      mack_now = ~sda_w; mlog[n_mack] = ~sda_w; n_mack++;
    end
  end
  always @(negedge scl_w) begin
    if (skip) skip = 0;
    else begin
      bitcnt++;
      if (bitcnt == 8) begin
        if (!in_read) begin
          if (n_wr < 16) wlog[n_wr] = sh;
          nk_now = (n_wr == nack_at);
          slave_pull = !nk_now;
          go_read = first_byte && sh[0] && !nk_now;
          first_byte = 0;
          n_wr++;
        end else slave_pull = 0;
      end else if (bitcnt == 9) begin
        bitcnt = 0; slave_pull = 0;
        if (go_read) begin
          go_read = 0; in_read = 1; rdi = 0; slave_pull = ~rsp[0][7];
        end else if (in_read) begin
          if (mack_now) begin rdi++; slave_pull = ~rsp[rdi][7]; end
          else in_read = 0;
        end
      end else if (in_read) slave_pull = ~rsp[rdi][7-bitcnt];
    end
  end

  // ---------------- stream capture ----------------
  logic [7:0] sbuf [0:299];
  logic       slast [0:299];
  int n_s;
  always @(negedge clk) if (rd_valid) begin
    if (n_s < 300) begin sbuf[n_s] = rd_byte; slast[n_s] = rd_last; end
    n_s++;
  end

  // ---------------- one transaction ----------------
  task automatic run_txn(input int kind, input logic [6:0] a, input logic [7:0] c,
                         input logic [15:0] wd, input int nk, input int bn);
    int txn, rx, slots, cyc, logged, starts;
    bit rd, nacked, tmo;
    logic [7:0] exp_b [0:3];
    rd  = (kind >= 3);
    txn = (kind == 0) ? 2 : (kind == 1) ? 3 : (kind == 2) ? 4 : 3;
    rx  = (kind == 3) ? 1 : (kind == 4) ? 2 : (kind == 5) ? bn + 1 : 0;
    for (int i = 0; i < 300; i++) rsp[i] = 8'((a * 7) + c + i * 29);
    if (kind == 5) rsp[0] = 8'(bn);
    exp_b[0] = {a, 1'b0}; exp_b[1] = c;
    exp_b[2] = rd ? {a, 1'b1} : wd[7:0]; exp_b[3] = wd[15:8];
    nacked = (nk >= 0) && (nk < txn);
    if (nacked) begin
      logged = nk + 1; rx = 0;
      slots = 2 + 9 * logged + ((rd && nk == 2) ? 1 : 0);
      starts = (rd && nk == 2) ? 2 : 1;
    end else begin
      logged = txn;
      slots = 2 + 9 * (txn + rx) + (rd ? 1 : 0);
      starts = rd ? 2 : 1;
    end
    n_wr = 0; n_start = 0; n_stop = 0; n_mack = 0; n_s = 0; nack_at = nk;
    @(negedge clk);
    chk("R11 ready before request", int'(req_ready), 1);
    req_valid = 1; req_kind = 3'(kind); req_addr = a; req_cmd = c; req_wdata = wd;
    @(posedge clk);
    cyc = 0; tmo = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R11 busy after accept", int'(req_ready), 0);
    while (!done) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc > 40000 || total_cyc > 195000) begin tmo = 1; break; end
    end
    chk("watchdog", int'(tmo), 0);
    chk("R9 cycles to done", cyc, slots * DIV);
    chk("R8 error flag", int'(error), int'(nacked));
    @(negedge clk);
    chk("R11 done single cycle", int'(done), 0);
    chk("R3 start count", n_start, starts);
    chk("R3 stop count", n_stop, 1);
    chk("R4 R5 bytes sent", n_wr, logged);
    for (int i = 0; i < logged && i < 4; i++) chk("R2 R4 R5 wire byte", int'(wlog[i]), int'(exp_b[i]));
    chk("R10 stream length", n_s, rx);
    chk("R6 R7 master ack count", n_mack, rx);
    for (int i = 0; i < rx && i < 300; i++) begin
      chk("R10 stream byte", int'(sbuf[i]), int'(rsp[i]));
      chk("R10 rd_last", int'(slast[i]), int'(i == rx - 1));
      chk("R6 R7 master ack", int'(mlog[i]), int'(i != rx - 1));
    end
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_kind = 0; req_addr = 0; req_cmd = 0; req_wdata = 0;
    n_s = 0; nack_at = -1; bitcnt = 0; skip = 0; in_read = 0; first_byte = 0; go_read = 0;
    repeat (3) @(negedge clk);
    chk("R1 scl released", int'(scl_oe), 0);
    chk("R1 sda released", int'(sda_oe), 0);
    chk("R1 busy low", int'(busy), 0);
    chk("R1 done low", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", int'(req_ready), 1);
    for (int k = 0; k < 6; k++) begin
      int tx = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 4 : 3;
      for (int nk = -1; nk < tx; nk++)
        run_txn(k, 7'(7'h5A ^ (k * 13 + nk + 1)), 8'(8'h8B + k * 17 + nk), 16'hC3A5 ^ 16'(k * 257), nk, 3);
    end
    run_txn(5, 7'h11, 8'hE6, 16'h0, -1, 0);
    run_txn(5, 7'h7F, 8'h01, 16'h0, -1, 1);
    run_txn(5, 7'h00, 8'hFF, 16'h0, -1, 2);
    run_txn(5, 7'h2B, 8'h9C, 16'h0, -1, 255);
    run_txn(2, 7'h7F, 8'hFF, 16'hFFFF, -1, 0);
    run_txn(2, 7'h00, 8'h00, 16'h0000, -1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule